// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the error bookkeeping of a CAN node. Two counters, one for receive errors and one for transmit errors, are moved up or down by single-cycle command pulses from the bit stream processor. From the two values the block derives which of three confinement states the node is in: error-active, error-passive or bus-off. It reports that state to the protocol sequencer as an encoded state and as two status flags.

When transmit errors drive the node off the bus, all counter commands are ignored. The node then watches the received bit stream through a per-bit tick with the sampled level. After enough runs of eleven consecutive recessive bits, it clears both counters and rejoins the bus as error-active. Reset is synchronous and active low.

Top module: `can_fault_conf`

## Requirements
- R1: After a cycle with `rst_n` low, both counters read 0, `node_state` is 0 (error-active), and `err_passive` and `bus_off` are low.
- R2: An increment pulse adds 1 to its counter when its size select (`rec_big`/`tec_big`) is low, and adds 8 when it is high. The new value is visible after the clock edge that samples the pulse.
- R3: If an increment and a decrement for the same counter arrive in the same cycle, only the increment is applied.
- R4: A decrement pulse subtracts 1. A counter at 0 stays at 0.
- R5: The receive counter saturates at 255 and never wraps.
- R6: A receive decrement while the receive counter is 128 or more loads 127.
- R7: `node_state` is 1 (error-passive) and `err_passive` is high exactly when the node is not bus-off and either counter is 128 or more. Otherwise, unless the node is bus-off, `node_state` is 0 and `err_passive` is low.
- R8: An increment that would take the transmit counter above 255 sets it to 256. At 256 the node is bus-off: `node_state` is 2, `bus_off` is high and `err_passive` is low.
- R9: While bus-off, every counter command is ignored and both counter values hold.
- R10: While bus-off, each bit tick with `bit_recessive` high extends a run, and a tick with it low restarts the run. Every eleventh consecutive recessive bit completes one run. On the tick that completes the 128th run, both counters are cleared and the node is error-active after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_inc | input | 1 | Receive counter increment pulse |
| rec_big | input | 1 | Receive increment size: 0 gives +1, 1 gives +8 |
| rec_dec | input | 1 | Receive counter decrement pulse |
| tec_inc | input | 1 | Transmit counter increment pulse |
| tec_big | input | 1 | Transmit increment size: 0 gives +1, 1 gives +8 |
| tec_dec | input | 1 | Transmit counter decrement pulse |
| bit_tick | input | 1 | One pulse per received bit |
| bit_recessive | input | 1 | Level of the ticked bit, 1 = recessive |
| rec_value | output | 8 | Receive error counter |
| tec_value | output | 9 | Transmit error counter |
| node_state | output | 2 | 0 error-active, 1 error-passive, 2 bus-off |
| err_passive | output | 1 | High in error-passive |
| bus_off | output | 1 | High in bus-off |

## Verification
The bench drives each counter exactly across the 127/128 boundary in both directions. A design with an off-by-one threshold would report the wrong state at 127 or 128. It pushes the receive counter to 255 and one past, where a wrapping counter would drop to a small value. It also overshoots the transmit counter with +8 from 252, so a design that neither clamps nor detects bus-off on overshoot would show 260 or stay passive. In bus-off it sends commands that must be ignored. It then sends recovery bit streams with a broken run and stops one bit short of the final run, which catches a run counter that does not restart on a dominant bit or recovers one run early.

// File: rtl/can_fc_pkg.sv
// Package: shared types for the CAN fault confinement unit.
// Assumes a two-bit encoding of the node state is decoded by the sequencer.
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

endpackage

// File: rtl/fc_err_counter.sv
// Module: one error counter driven by increment/decrement pulses.
// IS_TX selects the variant:
//   1 - clamps at 2^(W-1) (the bus-off mark) and floors at zero.
//   0 - saturates at 2^W-1, and a decrement at or above PASS_LIM loads PASS_LIM-1.
// Assumes the command pulses are one cycle wide. Increment wins over decrement.
// Hold freezes the value. Clear has priority over every command.
module fc_err_counter #(
    parameter int W        = 8,
    parameter int STEP_BIG = 8,
    parameter int PASS_LIM = 128,
    parameter bit IS_TX    = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         clear,
    input  logic         inc,
    input  logic         big,
    input  logic         dec,
    output logic [W-1:0] value
);
    localparam int         TOP_I  = IS_TX ? (1 << (W - 1)) : ((1 << W) - 1);
    localparam logic [W:0] TOP    = (W + 1)'(TOP_I);
    localparam logic [W:0] STEP_L = (W + 1)'(STEP_BIG);
    localparam logic [W:0] STEP_S = (W + 1)'(1);

    logic [W:0]   sum_ext;
    logic [W-1:0] up_val;
    logic [W-1:0] dn_val;

    // Purpose: add the selected step and clamp at the variant's ceiling.
    always_comb begin
        sum_ext = {1'b0, value} + (big ? STEP_L : STEP_S);
        up_val  = (sum_ext > TOP) ? TOP[W-1:0] : sum_ext[W-1:0];
    end

    generate
        if (IS_TX) begin : g_tx_dec
            // Purpose: plain decrement with a floor at zero.
            always_comb begin
                dn_val = (value == '0) ? '0 : value - W'(1);
            end
        end else begin : g_rx_dec
            localparam logic [W-1:0] PASS = W'(PASS_LIM);
            // Purpose: drop back below the passive mark, else decrement with floor.
            always_comb begin
                if (value >= PASS) begin
                    dn_val = PASS - W'(1);
                end else if (value == '0) begin
                    dn_val = '0;
                end else begin
                    dn_val = value - W'(1);
                end
            end
        end
    endgenerate

    // Purpose: counter register with reset, clear, hold and command priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            value <= '0;
        end else if (hold) begin
            value <= value;
        end else if (inc) begin
            value <= up_val;
        end else if (dec) begin
            value <= dn_val;
        end
    end

endmodule

// File: rtl/fc_state_derive.sv
// Module: maps the two counter values onto the confinement state.
// Assumes the transmit counter reaches 2^(TEC_W-1) only when bus-off.
// Purely combinational. Both inputs are registered upstream.
module fc_state_derive
    import can_fc_pkg::*;
#(
    parameter int REC_W    = 8,
    parameter int TEC_W    = 9,
    parameter int PASS_LIM = 128
) (
    input  logic [REC_W-1:0] rec,
    input  logic [TEC_W-1:0] tec,
    output fc_state_e        state,
    output logic             err_passive,
    output logic             bus_off
);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASS_LIM);
    localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(1 << (TEC_W - 1));

    // Purpose: bus-off dominates, then the passive thresholds.
    always_comb begin
        bus_off     = (tec >= TEC_OFF);
        err_passive = !bus_off && ((rec >= REC_PASS) || (tec >= TEC_PASS));
        if (bus_off) begin
            state = FC_BUSOFF;
        end else if (err_passive) begin
            state = FC_PASSIVE;
        end else begin
            state = FC_ACTIVE;
        end
    end

endmodule

// File: rtl/fc_recovery.sv
// Module: counts runs of RUN_LEN consecutive recessive bits while enabled.
// Emits a one-cycle recover pulse on the tick completing run RUN_COUNT.
// Assumes bit_tick is a one-cycle pulse per bit. Disabled means counting from zero.
module fc_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_tick,
    input  logic bit_recessive,
    output logic recover
);
    localparam int               RUN_W    = $clog2(RUN_LEN);
    localparam int               SEQ_W    = $clog2(RUN_COUNT);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RUN_COUNT - 1);

    logic [RUN_W-1:0] run_q;
    logic [SEQ_W-1:0] seq_q;
    logic             run_done;

    // Purpose: detect the bit that closes a run and the run that closes recovery.
    always_comb begin
        run_done = enable && bit_tick && bit_recessive && (run_q == RUN_LAST);
        recover  = run_done && (seq_q == SEQ_LAST);
    end

    // Purpose: track bits in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q <= '0;
        end else if (bit_tick) begin
            if (!bit_recessive || run_done) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    // Purpose: track completed runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || recover) begin
            seq_q <= '0;
        end else if (run_done) begin
            seq_q <= seq_q + SEQ_W'(1);
        end
    end

endmodule

// File: rtl/can_fault_conf.sv
// Module: CAN fault confinement top level.
// Holds receive and transmit error counters and derives the node state from them.
// Gates commands while bus-off and runs the recovery counter.
// Assumes all command and bit-tick inputs are synchronous one-cycle pulses.
module can_fault_conf
    import can_fc_pkg::*;
#(
    parameter int REC_W     = 8,
    parameter int STEP_BIG  = 8,
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_inc,
    input  logic             rec_big,
    input  logic             rec_dec,
    input  logic             tec_inc,
    input  logic             tec_big,
    input  logic             tec_dec,
    input  logic             bit_tick,
    input  logic             bit_recessive,
    output logic [REC_W-1:0] rec_value,
    output logic [REC_W:0]   tec_value,
    output logic [1:0]       node_state,
    output logic             err_passive,
    output logic             bus_off
);
    localparam int TEC_W    = REC_W + 1;
    localparam int PASS_LIM = 1 << (REC_W - 1);

    fc_state_e state_w;
    logic      recover_w;

    fc_err_counter #(
        .W(REC_W), .STEP_BIG(STEP_BIG), .PASS_LIM(PASS_LIM), .IS_TX(1'b0)
    ) u_rec (
        .clk(clk), .rst_n(rst_n), .hold(bus_off), .clear(recover_w),
        .inc(rec_inc), .big(rec_big), .dec(rec_dec), .value(rec_value)
    );

    fc_err_counter #(
        .W(TEC_W), .STEP_BIG(STEP_BIG), .PASS_LIM(PASS_LIM), .IS_TX(1'b1)
    ) u_tec (
        .clk(clk), .rst_n(rst_n), .hold(bus_off), .clear(recover_w),
        .inc(tec_inc), .big(tec_big), .dec(tec_dec), .value(tec_value)
    );

    fc_state_derive #(
        .REC_W(REC_W), .TEC_W(TEC_W), .PASS_LIM(PASS_LIM)
    ) u_state (
        .rec(rec_value), .tec(tec_value), .state(state_w),
        .err_passive(err_passive), .bus_off(bus_off)
    );

    fc_recovery #(
        .RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)
    ) u_rcv (
        .clk(clk), .rst_n(rst_n), .enable(bus_off), .bit_tick(bit_tick),
        .bit_recessive(bit_recessive), .recover(recover_w)
    );

    // Purpose: present the encoded state on the port.
    always_comb begin
        node_state = state_w;
    end

endmodule

// File: rtl/can_fault_conf_chk.sv
// Module: property checker for the fault confinement unit. Attached by bind.
// Assumes synchronous active-low reset. All properties are disabled while reset is low.
module can_fault_conf_chk #(
    parameter int REC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_inc,
    input logic             rec_big,
    input logic             rec_dec,
    input logic             tec_inc,
    input logic             tec_big,
    input logic             tec_dec,
    input logic [REC_W-1:0] rec_value,
    input logic [REC_W:0]   tec_value,
    input logic             err_passive,
    input logic             bus_off,
    input logic             recover
);
    localparam logic [REC_W-1:0] REC_MAX  = '1;
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(1 << (REC_W - 1));
    localparam logic [REC_W:0]   TEC_OFF  = (REC_W + 1)'(1 << REC_W);
    localparam logic [REC_W:0]   TEC_BIGL = TEC_OFF - (REC_W + 1)'(8);

    // R8: transmit counter never goes past the bus-off mark
    p_tec_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tec_value <= TEC_OFF);

    // R7: passive and bus-off flags are exclusive
    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_passive && bus_off));

    // R7: a high receive counter outside bus-off means passive
    p_rec_passive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_value >= REC_PASS && !bus_off) |-> err_passive);

    // R2: a single-step receive increment adds one
    p_rec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && !recover && rec_inc && !rec_big && rec_value != REC_MAX)
        |=> rec_value == $past(rec_value) + REC_W'(1));

    // R2: a large transmit increment adds eight below the clamp zone
    p_tec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && !recover && tec_inc && tec_big && tec_value < TEC_BIGL)
        |=> tec_value == $past(tec_value) + (REC_W + 1)'(8));

    // R3: increment wins over a simultaneous decrement
    p_rec_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && !recover && rec_inc && rec_dec && rec_value != REC_MAX)
        |=> rec_value > $past(rec_value));

    // R4: decrement at zero stays at zero
    p_tec_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_off && !recover && tec_dec && !tec_inc && tec_value == '0)
        |=> tec_value == '0);

    // R9: counters hold while bus-off unless recovery completes
    p_busoff_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !recover) |=> ($stable(rec_value) && $stable(tec_value)));

    // R10: recovery leaves both counters cleared and the node error-active
    p_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> (rec_value == '0 && tec_value == '0 && !bus_off && !err_passive));

endmodule

bind can_fault_conf can_fault_conf_chk #(.REC_W(REC_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rec_inc(rec_inc), .rec_big(rec_big), .rec_dec(rec_dec),
    .tec_inc(tec_inc), .tec_big(tec_big), .tec_dec(tec_dec),
    .rec_value(rec_value), .tec_value(tec_value),
    .err_passive(err_passive), .bus_off(bus_off), .recover(recover_w)
);

// File: tb/can_fault_conf_bench.sv
module can_fault_conf_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rec_inc = 1'b0, rec_big = 1'b0, rec_dec = 1'b0;
    logic       tec_inc = 1'b0, tec_big = 1'b0, tec_dec = 1'b0;
    logic       bit_tick = 1'b0, bit_recessive = 1'b0;
    logic [7:0] rec_value;
    logic [8:0] tec_value;
    logic [1:0] node_state;
    logic       err_passive, bus_off;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_fault_conf u_can_fault_conf (
        .clk(clk), .rst_n(rst_n),
        .rec_inc(rec_inc), .rec_big(rec_big), .rec_dec(rec_dec),
        .tec_inc(tec_inc), .tec_big(tec_big), .tec_dec(tec_dec),
        .bit_tick(bit_tick), .bit_recessive(bit_recessive),
        .rec_value(rec_value), .tec_value(tec_value), .node_state(node_state),
        .err_passive(err_passive), .bus_off(bus_off)
    );

    // cmd bits: {rec_inc, rec_big, rec_dec, tec_inc, tec_big, tec_dec}
    typedef struct packed {
        logic [5:0] cmd;
        logic [7:0] reps;
        logic [7:0] e_rec;
        logic [8:0] e_tec;
        logic [1:0] e_st;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{6'b110000, 8'd1,   8'd8,   9'd0,   2'd0},  // R2 rec +8
        '{6'b000110, 8'd1,   8'd8,   9'd8,   2'd0},  // R2 tec +8
        '{6'b101000, 8'd1,   8'd9,   9'd8,   2'd0},  // R3 inc wins
        '{6'b000001, 8'd1,   8'd9,   9'd7,   2'd0},  // R4 tec -1
        '{6'b001000, 8'd1,   8'd8,   9'd7,   2'd0},  // R4 rec -1
        '{6'b110000, 8'd15,  8'd128, 9'd7,   2'd1},  // R7 rec at 128
        '{6'b001000, 8'd1,   8'd127, 9'd7,   2'd0},  // R6 back to 127
        '{6'b110000, 8'd16,  8'd255, 9'd7,   2'd1},  // R5 reach 255
        '{6'b100000, 8'd1,   8'd255, 9'd7,   2'd1},  // R5 saturate
        '{6'b001000, 8'd1,   8'd127, 9'd7,   2'd0},  // R6 from 255
        '{6'b000001, 8'd8,   8'd127, 9'd0,   2'd0},  // R4 tec floor
        '{6'b001000, 8'd130, 8'd0,   9'd0,   2'd0},  // R4 rec floor
        '{6'b000110, 8'd16,  8'd0,   9'd128, 2'd1},  // R7 tec at 128
        '{6'b000001, 8'd1,   8'd0,   9'd127, 2'd0},  // R7 tec at 127
        '{6'b000110, 8'd16,  8'd0,   9'd255, 2'd1},  // R7 tec at 255
        '{6'b000100, 8'd1,   8'd0,   9'd256, 2'd2},  // R8 bus-off
        '{6'b110000, 8'd3,   8'd0,   9'd256, 2'd2},  // R9 rec ignored
        '{6'b000001, 8'd5,   8'd0,   9'd256, 2'd2},  // R9 tec ignored
        '{6'b001101, 8'd2,   8'd0,   9'd256, 2'd2}   // R9 mixed ignored
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input int e_rec, input int e_tec, input int e_st);
        chk(req, int'(rec_value), e_rec);
        chk(req, int'(tec_value), e_tec);
        chk(req, int'(node_state), e_st);
        chk(req, int'(err_passive), (e_st == 1) ? 1 : 0);
        chk(req, int'(bus_off), (e_st == 2) ? 1 : 0);
    endtask

    task automatic pulse(input logic [5:0] c);
        @(negedge clk);
        {rec_inc, rec_big, rec_dec, tec_inc, tec_big, tec_dec} = c;
        @(negedge clk);
        {rec_inc, rec_big, rec_dec, tec_inc, tec_big, tec_dec} = 6'b0;
    endtask

    task automatic send_bit(input logic lvl);
        @(negedge clk);
        bit_tick = 1'b1;
        bit_recessive = lvl;
        @(negedge clk);
        bit_tick = 1'b0;
        bit_recessive = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        chk_state("R1 reset", 0, 0, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < int'(VEC[i].reps); k++) pulse(VEC[i].cmd);
            chk_state($sformatf("table step %0d", i),
                      int'(VEC[i].e_rec), int'(VEC[i].e_tec), int'(VEC[i].e_st));
        end

        // R10: broken run, then 127 full runs: still bus-off
        for (int b = 0; b < 10; b++) send_bit(1'b1);
        send_bit(1'b0);
        for (int r = 0; r < 127; r++)
            for (int b = 0; b < 11; b++) send_bit(1'b1);
        for (int b = 0; b < 10; b++) send_bit(1'b1);
        chk_state("R10 one bit short", 0, 256, 2);
        send_bit(1'b1);
        chk_state("R10 recovered", 0, 0, 0);

        // R10: recessive bits outside bus-off have no effect
        pulse(6'b000110);
        for (int b = 0; b < 30; b++) send_bit(1'b1);
        chk_state("R10 ignored when active", 0, 8, 0);

        // R1: reset mid-operation clears state
        pulse(6'b110000);
        do_reset();
        chk_state("R1 mid reset", 0, 0, 0);

        // R8: overshoot with +8 from 252 clamps to 256
        for (int k = 0; k < 31; k++) pulse(6'b000110);
        for (int k = 0; k < 4; k++) pulse(6'b000100);
        chk_state("R8 at 252", 0, 252, 1);
        pulse(6'b000110);
        chk_state("R8 overshoot clamp", 0, 256, 2);

        // R2: single-step receive increment from zero
        do_reset();
        pulse(6'b100000);
        chk_state("R2 rec +1", 1, 0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule